// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources into groups of eight, and drives one output line per group toward a parent interrupt controller. A group's line stays high for as long as any source in that group is both active and enabled. Software controls the enables through a small register bus, and each enable bit belongs to exactly one source.

Four groups share one 32-bit register bank, one byte lane each, and the banks sit at a fixed 16-byte stride. Enables are never written directly. One address sets every bit written as 1, a second address clears every bit written as 1, and bits written as 0 are left alone. The set address also reads back the current enables, so software can save them and later restore them. A third address returns, for each source, whether it is active and enabled. All other offsets are reserved.

The register bus carries single-cycle control accesses with no stall, so it has plain pins and no valid/ready handshake. The interrupt inputs are levels and the group outputs are levels.

Top module: `irq_combiner`

## Requirements
- R1: Output line `irq_out[n]` is high exactly when some `k` in 0..7 has both `irq_src[8n+k]` high and enable bit `8n+k` set. The output follows `irq_src` in the same cycle, with no register on that path.
- R2: Group `n` lives in bank `n/4`, whose byte address base is `(n/4)*16`. Its enables occupy bits `[8*(n%4)+7 : 8*(n%4)]` of that bank's 32-bit registers, and bit `k` of the lane is source `8n+k`.
- R3: A write to bank offset 0x0 sets every enable bit whose data bit is 1 and leaves the other bits unchanged. The new value is visible from the cycle after the write edge.
- R4: A write to bank offset 0x4 clears every enable bit whose data bit is 1 and leaves the other bits unchanged.
- R5: A read of bank offset 0x0 returns that bank's current enable bits. Read data depends on the address in the same cycle.
- R6: A read of bank offset 0xC returns `irq_src & enable` for that bank's 32 sources, in the same lane layout as R2.
- R7: After reset every enable bit is 0, so every `irq_out` is low whatever the sources do.
- R8: Reserved addresses read as zero, and writes to them change no enable bit. The reserved addresses are offset 0x8, any offset whose low nibble is not 0x0, 0x4 or 0xC, and any bank index at or above the number of banks.
- R9: One access is taken per cycle. When a set write and a clear write of the same bit arrive on back-to-back cycles, the bit ends in the state chosen by the later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe; when low, the cycle is a read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_src | input | NUM_GROUPS*8 | Level interrupt sources |
| irq_out | output | NUM_GROUPS | One combined line per group |

## Verification
A walking single enable is swept across every one of the 160 sources. It is tried once with all sources high, which shows that exactly the owning group fires and that the bank and lane mapping is right. It is tried again with only that source low, which shows that no other source leaks through the enable. Each bank then gets a distinct arithmetic set pattern, a partial clear and a mixed source pattern, which separate set from clear semantics and show that status is an AND of source and enable rather than either one alone. Reserved-address writes with all ones, followed by readback, and back-to-back set and clear pairs in both orders cover the decode holes and the ordering rule.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LANES       = 4;
  localparam int LANE_W      = 8;
  localparam int BANK_W      = LANES * LANE_W;
  localparam int STRIDE_BITS = 4;

  localparam logic [STRIDE_BITS-1:0] OFS_SET  = 4'h0;
  localparam logic [STRIDE_BITS-1:0] OFS_CLR  = 4'h4;
  localparam logic [STRIDE_BITS-1:0] OFS_STAT = 4'hC;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_STAT
  } acc_e;

  // Mask of the byte lanes that hold real groups in a bank.
  function automatic logic [BANK_W-1:0] live_mask(input int live_lanes);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < live_lanes) m[i*LANE_W +: LANE_W] = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  output acc_e                 kind,
  output logic [NUM_BANKS-1:0] bank_hit
);
  localparam int IDX_W = ADDR_W - STRIDE_BITS;

  logic [IDX_W-1:0]       idx;
  logic [STRIDE_BITS-1:0] ofs;

  assign idx = addr[ADDR_W-1:STRIDE_BITS];
  assign ofs = addr[STRIDE_BITS-1:0];

  always_comb begin
    unique case (ofs)
      OFS_SET:  kind = ACC_SET;
      OFS_CLR:  kind = ACC_CLR;
      OFS_STAT: kind = ACC_STAT;
      default:  kind = ACC_NONE;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (idx == IDX_W'(b));
  end
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
  import irqc_pkg::*;
#(
  parameter int LIVE_LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en
);
  localparam logic [BANK_W-1:0] LIVE = live_mask(LIVE_LANES);

  logic [BANK_W-1:0] set_bits, clr_bits, en_q;

  assign set_bits = set_we ? (wdata & LIVE) : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_bits) & ~clr_bits & LIVE;
  end

  assign en = en_q;

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en & $past(wdata & LIVE)) == $past(wdata & LIVE)));

  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en & $past(wdata)) == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/irqc_group_or.sv
module irqc_group_or
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] src,
  input  logic [LANE_W-1:0] en,
  output logic              irq
);
  assign irq = |(src & en);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [BANK_W-1:0]            bus_wdata,
  output logic [BANK_W-1:0]            bus_rdata,
  input  logic [NUM_GROUPS*LANE_W-1:0] irq_src,
  output logic [NUM_GROUPS-1:0]        irq_out
);
  localparam int NUM_BANKS = (NUM_GROUPS + LANES - 1) / LANES;
  localparam int NUM_SRC   = NUM_GROUPS * LANE_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;

  acc_e                 kind;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] set_we, clr_we;
  logic [PAD_W-1:0]     src_pad, en_all;

  irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr     (bus_addr),
    .kind     (kind),
    .bank_hit (bank_hit)
  );

  if (PAD_W > NUM_SRC) begin : g_pad
    assign src_pad = {{(PAD_W-NUM_SRC){1'b0}}, irq_src};
  end else begin : g_nopad
    assign src_pad = irq_src;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LIVE = (NUM_GROUPS - b*LANES) < LANES ? (NUM_GROUPS - b*LANES) : LANES;
    assign set_we[b] = bus_we && bank_hit[b] && (kind == ACC_SET);
    assign clr_we[b] = bus_we && bank_hit[b] && (kind == ACC_CLR);

    irqc_enable_bank #(.LIVE_LANES(LIVE)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .wdata  (bus_wdata),
      .en     (en_all[b*BANK_W +: BANK_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqc_group_or u_or (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_pad[g*LANE_W +: LANE_W]),
      .en    (en_all[g*LANE_W +: LANE_W]),
      .irq   (irq_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        if (kind == ACC_SET)
          bus_rdata = en_all[b*BANK_W +: BANK_W];
        else if (kind == ACC_STAT)
          bus_rdata = en_all[b*BANK_W +: BANK_W] & src_pad[b*BANK_W +: BANK_W];
      end
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_we, clr_we}));

  // R6
  status_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && kind == ACC_STAT && bus_rdata != '0) |-> (irq_out != '0));

  // R8
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit == '0 || kind == ACC_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 20;
  localparam int NS = NG * 8;
  localparam int NB = 5;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NS-1:0] irq_src = '0;
  logic [NG-1:0] irq_out;

  logic [NS-1:0] en_m = '0;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_irq();
    logic [NG-1:0] e;
    for (int g = 0; g < NG; g++) e[g] = |(irq_src[g*8 +: 8] & en_m[g*8 +: 8]);
    return e;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    int b;
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    b = int'(a[AW-1:4]);
    if (b < NB) begin
      if (a[3:0] == 4'h0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
      else if (a[3:0] == 4'h4) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 0;
    #1 v = bus_rdata;
    @(negedge clk);
  endtask

  task automatic chk_irq(string req);
    #1 chk(req, 32'(irq_out), 32'(exp_irq()));
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R7: reset state
    irq_src = '1;
    chk_irq("R7");
    for (int b = 0; b < NB; b++) begin
      rd(AW'(b*16), v);      chk("R7", v, 32'h0);
      rd(AW'(b*16 + 12), v); chk("R7", v, 32'h0);
    end

    // R1 R2 R3 R5: walk one enable over every source
    for (int s = 0; s < NS; s++) begin
      wr(AW'((s/32)*16), 32'h1 << (s%32));
      irq_src = '1;
      #1 chk("R1 R2", 32'(irq_out), 32'h1 << (s/8));
      @(negedge clk);
      rd(AW'((s/32)*16), v); chk("R5", v, 32'h1 << (s%32));
      irq_src = ~({{(NS-1){1'b0}}, 1'b1} << s);
      #1 chk("R1", 32'(irq_out), 32'h0);
      @(negedge clk);
      wr(AW'((s/32)*16 + 4), 32'h1 << (s%32));
    end

    // R3 R4 R6: per-bank patterns
    for (int b = 0; b < NB; b++) begin
      logic [31:0] p, c, q;
      p = 32'hA5C3_0F96 ^ (32'(b) * 32'h0107_0B0D);
      c = 32'h0F0F_F00F ^ (32'(b) * 32'h1111_1111);
      q = 32'h3C3C_9A65 + 32'(b) * 32'h2468_ACE1;
      wr(AW'(b*16), p);
      rd(AW'(b*16), v); chk("R3", v, en_m[b*32 +: 32]);
      irq_src = '0;
      irq_src[b*32 +: 32] = q;
      rd(AW'(b*16 + 12), v); chk("R6", v, q & en_m[b*32 +: 32]);
      chk_irq("R1");
      wr(AW'(b*16 + 4), c);
      rd(AW'(b*16), v); chk("R4", v, en_m[b*32 +: 32]);
      rd(AW'(b*16 + 12), v); chk("R6", v, q & en_m[b*32 +: 32]);
      chk_irq("R1");
    end

    // R8: reserved addresses
    irq_src = '1;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) begin
      rd(AW'(b*16), v); chk("R8", v, en_m[b*32 +: 32]);
    end
    chk_irq("R8");
    rd(8'h08, v); chk("R8", v, 32'h0);
    rd(8'h0D, v); chk("R8", v, 32'h0);
    rd(8'h50, v); chk("R8", v, 32'h0);
    rd(8'hFC, v); chk("R8", v, 32'h0);

    // R9: back-to-back set/clear in both orders
    wr(8'h20, 32'h0000_8000);
    wr(8'h24, 32'h0000_8000);
    rd(8'h20, v); chk("R9", 32'(v[15]), 32'h0);
    wr(8'h24, 32'h0001_0000);
    wr(8'h20, 32'h0001_0000);
    rd(8'h20, v); chk("R9", 32'(v[16]), 32'h1);
    chk("R9", v, en_m[64 +: 32]);

    finish_run();
  end
endmodule